// File: doc/BRIEF.md
# Host-to-PCI Address Window Decoder

This block sits between a processor-side memory-mapped request port and a downstream PCI-style request/response port. Every accepted processor access is classified by address into one of four targets: PCI I/O space, PCI configuration space, the interrupt-acknowledge byte, or PCI memory space. Addresses outside these windows, and transfer sizes the block does not support, are answered locally with an error.

For I/O accesses the processor address is rewritten into an I/O port number by one of two mappings. The contiguous mapping keeps the low 16 address bits. The packed mapping folds an 8 MB processor window into a 16-bit port space: the page number sits directly above a 5-bit in-page offset. A one-bit mode register picks the mapping. It lives at I/O port 0x850 and is reached through the I/O window itself, so it is not forwarded downstream. Configuration accesses are turned into a register offset plus a device index taken from the lowest set select bit.

The block handles one transaction at a time. A forwarded access goes out as a single-cycle downstream request and completes when the downstream port answers. A local access (an error, or the mode register) completes one cycle after it is accepted.

Top module: `pci_window_decoder`

## Requirements
- R1: After reset, `cpu_req_ready` is 1, `cpu_rsp_valid` and `dn_req_valid` are 0, and the I/O mapping mode is contiguous.
- R2: A processor address in [0x8000_0000, 0x8080_0000) with mode 0 is forwarded with kind 2'b01 (I/O), and the downstream address is the processor address bits [15:0], zero-extended.
- R3: With mode 1, an I/O-window access is forwarded with the port address {addr[22:12], addr[4:0]}. Processor address bits [11:5] are dropped.
- R4: A 1-byte I/O-window access whose translated port is 0x850 is not forwarded. A write sets the mode to `cpu_req_wdata[0]` and returns read data 0. A read returns {31'b0, mode}. The new mode applies to the next accepted access.
- R5: An address in [0x8080_0000, 0x80C0_0000) is forwarded with kind 2'b10 (config). The downstream address is offset[10:0] ORed with P shifted left by 11. The offset is the address minus 0x8080_0000. P is the position of the lowest set bit among offset bits [21:11], or 32 if none of them is set.
- R6: A 1-byte read of 0xBFFF_FFF0 is forwarded with kind 2'b11 (interrupt acknowledge), address 0 and byte enables 8'h01. A write to that address, or any other size there, is an error.
- R7: An address at or above 0xC000_0000 is forwarded with kind 2'b00 (memory) and downstream address equal to the processor address minus 0xC000_0000.
- R8: Legal sizes are 1, 2 and 4 bytes, coded as that byte count on `cpu_req_size`, and they may be unaligned. `dn_req_be` is ((1 << size) - 1) shifted left by addr[1:0], over 8 byte lanes. `dn_req_write` and `dn_req_wdata` are copied from the accepted request.
- R9: An illegal size, or an address outside all windows, produces no downstream request. The block responds one cycle after acceptance with `cpu_rsp_err` = 1 and read data all ones.
- R10: A forwarded access raises `dn_req_valid` for exactly one cycle, in the cycle after acceptance. `cpu_req_ready` stays 0 until the response. `cpu_rsp_valid` rises in the cycle after `dn_rsp_valid`, carrying `dn_rsp_rdata` with `cpu_rsp_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Block can accept a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 32 | Processor byte address |
| cpu_req_size | input | 3 | Transfer size in bytes |
| cpu_req_wdata | input | 32 | Write data, little-endian |
| cpu_rsp_valid | output | 1 | Response strobe |
| cpu_rsp_err | output | 1 | Response is an error |
| cpu_rsp_rdata | output | 32 | Read data |
| dn_req_valid | output | 1 | Downstream request strobe |
| dn_req_kind | output | 2 | 00 memory, 01 I/O, 10 config, 11 intack |
| dn_req_addr | output | 32 | Translated address |
| dn_req_be | output | 8 | Byte-lane enables |
| dn_req_write | output | 1 | Downstream write |
| dn_req_wdata | output | 32 | Downstream write data |
| dn_rsp_valid | input | 1 | Downstream response strobe |
| dn_rsp_rdata | input | 32 | Downstream read data |

## Verification
The assertions assume that the downstream port answers only while a forwarded request is outstanding, and answers exactly once per request. The bench keeps to this by driving `dn_rsp_valid` only after it has seen the request, and holding it for a single cycle after a random delay of zero to three cycles. They also assume the processor offers a new request only while `cpu_req_ready` is high. The bench waits for ready before each access and drops valid right after it is accepted. The stimulus mixes random addresses in every window and in the gaps between them, random sizes from 0 to 7, and writes that flip the mapping mode.

// File: rtl/pwd_pkg.sv
package pwd_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int LANES  = 8;

    typedef enum logic [1:0] {
        KIND_MEM    = 2'b00,
        KIND_IO     = 2'b01,
        KIND_CFG    = 2'b10,
        KIND_INTACK = 2'b11
    } kind_e;

    typedef struct packed {
        logic              err;
        logic              local_acc;
        kind_e             kind;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  be;
    } decode_t;

    function automatic logic size_legal(input logic [2:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction

endpackage

// File: rtl/pwd_io_remap.sv
module pwd_io_remap #(
    parameter int PORT_W      = 16,
    parameter int IO_WIN_LOG2 = 23,
    parameter int PAGE_LSB    = 12,
    parameter int OFF_W       = 5
) (
    input  logic [pwd_pkg::ADDR_W-1:0] addr_i,
    input  logic                       packed_i,
    output logic [PORT_W-1:0]          port_o
);
    localparam int PAGE_W = IO_WIN_LOG2 - PAGE_LSB;
    localparam int PACK_W = PAGE_W + OFF_W;

    logic [PACK_W-1:0] packed_port;
    logic [PORT_W-1:0] flat_port;

    assign packed_port = {addr_i[IO_WIN_LOG2-1:PAGE_LSB], addr_i[OFF_W-1:0]};
    assign flat_port   = addr_i[PORT_W-1:0];

    generate
        if (PACK_W >= PORT_W) begin : g_trunc
            assign port_o = packed_i ? packed_port[PORT_W-1:0] : flat_port;
        end else begin : g_pad
            assign port_o = packed_i ? {{(PORT_W-PACK_W){1'b0}}, packed_port} : flat_port;
        end
    endgenerate
endmodule

// File: rtl/pwd_cfg_remap.sv
module pwd_cfg_remap #(
    parameter int CFG_WIN_LOG2 = 22,
    parameter int REG_W        = 11
) (
    input  logic [CFG_WIN_LOG2-1:0]    offset_i,
    output logic [pwd_pkg::ADDR_W-1:0] cfg_o
);
    localparam int POS_W = 6;

    logic [POS_W-1:0] sel_pos;

    always_comb begin
        sel_pos = POS_W'(32);
        for (int i = CFG_WIN_LOG2 - 1; i >= REG_W; i--) begin
            if (offset_i[i]) sel_pos = POS_W'(i);
        end
        cfg_o = ({{(pwd_pkg::ADDR_W-POS_W){1'b0}}, sel_pos} << REG_W)
              | {{(pwd_pkg::ADDR_W-REG_W){1'b0}}, offset_i[REG_W-1:0]};
    end
endmodule

// File: rtl/pwd_lane_mask.sv
module pwd_lane_mask #(
    parameter int LANES = 8
) (
    input  logic [1:0]       lo_i,
    input  logic [2:0]       size_i,
    output logic [LANES-1:0] be_o
);
    localparam int CW = 4;

    logic [CW-1:0] first;
    logic [CW-1:0] last_excl;

    assign first     = {2'b00, lo_i};
    assign last_excl = first + {1'b0, size_i};

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            assign be_o[k] = (CW'(k) >= first) && (CW'(k) < last_excl);
        end
    endgenerate
endmodule

// File: rtl/pwd_window_decode.sv
module pwd_window_decode
    import pwd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] IO_BASE      = 32'h8000_0000,
    parameter int                IO_WIN_LOG2  = 23,
    parameter logic [ADDR_W-1:0] CFG_BASE     = 32'h8080_0000,
    parameter int                CFG_WIN_LOG2 = 22,
    parameter logic [ADDR_W-1:0] INTACK_ADDR  = 32'hBFFF_FFF0,
    parameter logic [ADDR_W-1:0] MEM_BASE     = 32'hC000_0000,
    parameter int                PORT_W       = 16,
    parameter logic [PORT_W-1:0] MAP_PORT     = 16'h0850
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [2:0]        size_i,
    input  logic              write_i,
    input  logic              map_i,
    output decode_t           dec_o
);
    logic              io_hit, cfg_hit, ia_hit, mem_hit, sz_ok;
    logic [PORT_W-1:0] io_port;
    logic [ADDR_W-1:0] cfg_addr;
    logic [LANES-1:0]  lanes;

    assign io_hit  = (addr_i >> IO_WIN_LOG2) == (IO_BASE >> IO_WIN_LOG2);
    assign cfg_hit = (addr_i >> CFG_WIN_LOG2) == (CFG_BASE >> CFG_WIN_LOG2);
    assign ia_hit  = (addr_i == INTACK_ADDR);
    assign mem_hit = (addr_i >= MEM_BASE);
    assign sz_ok   = size_legal(size_i);

    pwd_io_remap #(
        .PORT_W(PORT_W), .IO_WIN_LOG2(IO_WIN_LOG2), .PAGE_LSB(12), .OFF_W(5)
    ) u_io (
        .addr_i(addr_i), .packed_i(map_i), .port_o(io_port)
    );

    pwd_cfg_remap #(
        .CFG_WIN_LOG2(CFG_WIN_LOG2), .REG_W(11)
    ) u_cfg (
        .offset_i(addr_i[CFG_WIN_LOG2-1:0]), .cfg_o(cfg_addr)
    );

    pwd_lane_mask #(.LANES(LANES)) u_lanes (
        .lo_i(addr_i[1:0]), .size_i(size_i), .be_o(lanes)
    );

    always_comb begin
        dec_o           = '0;
        dec_o.be        = lanes;
        dec_o.kind      = KIND_MEM;
        if (io_hit) begin
            dec_o.kind      = KIND_IO;
            dec_o.addr      = {{(ADDR_W-PORT_W){1'b0}}, io_port};
            dec_o.local_acc = (size_i == 3'd1) && (io_port == MAP_PORT);
        end else if (cfg_hit) begin
            dec_o.kind = KIND_CFG;
            dec_o.addr = cfg_addr;
        end else if (ia_hit) begin
            dec_o.kind = KIND_INTACK;
            dec_o.addr = '0;
            dec_o.err  = write_i || (size_i != 3'd1);
        end else if (mem_hit) begin
            dec_o.kind = KIND_MEM;
            dec_o.addr = addr_i - MEM_BASE;
        end else begin
            dec_o.err = 1'b1;
        end
        if (!sz_ok) dec_o.err = 1'b1;
        if (dec_o.err) dec_o.local_acc = 1'b0;
    end
endmodule

// File: rtl/pci_window_decoder.sv
module pci_window_decoder
    import pwd_pkg::*;
#(
    parameter logic [31:0] IO_BASE      = 32'h8000_0000,
    parameter int          IO_WIN_LOG2  = 23,
    parameter logic [31:0] CFG_BASE     = 32'h8080_0000,
    parameter int          CFG_WIN_LOG2 = 22,
    parameter logic [31:0] INTACK_ADDR  = 32'hBFFF_FFF0,
    parameter logic [31:0] MEM_BASE     = 32'hC000_0000,
    parameter logic [15:0] MAP_PORT     = 16'h0850
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req_valid,
    output logic        cpu_req_ready,
    input  logic        cpu_req_write,
    input  logic [31:0] cpu_req_addr,
    input  logic [2:0]  cpu_req_size,
    input  logic [31:0] cpu_req_wdata,
    output logic        cpu_rsp_valid,
    output logic        cpu_rsp_err,
    output logic [31:0] cpu_rsp_rdata,
    output logic        dn_req_valid,
    output logic [1:0]  dn_req_kind,
    output logic [31:0] dn_req_addr,
    output logic [7:0]  dn_req_be,
    output logic        dn_req_write,
    output logic [31:0] dn_req_wdata,
    input  logic        dn_rsp_valid,
    input  logic [31:0] dn_rsp_rdata
);
    typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} st_e;

    typedef struct packed {
        st_e               st;
        logic              map;
        logic              rsp_valid;
        logic              rsp_err;
        logic [DATA_W-1:0] rsp_rdata;
        logic              dn_valid;
        kind_e             dn_kind;
        logic [ADDR_W-1:0] dn_addr;
        logic [LANES-1:0]  dn_be;
        logic              dn_write;
        logic [DATA_W-1:0] dn_wdata;
    } state_t;

    state_t  state_d, state_q;
    decode_t dec;
    logic    accept;
    logic    map_wr_accept;

    pwd_window_decode #(
        .IO_BASE(IO_BASE), .IO_WIN_LOG2(IO_WIN_LOG2),
        .CFG_BASE(CFG_BASE), .CFG_WIN_LOG2(CFG_WIN_LOG2),
        .INTACK_ADDR(INTACK_ADDR), .MEM_BASE(MEM_BASE),
        .PORT_W(16), .MAP_PORT(MAP_PORT)
    ) u_decode (
        .addr_i(cpu_req_addr), .size_i(cpu_req_size), .write_i(cpu_req_write),
        .map_i(state_q.map), .dec_o(dec)
    );

    assign accept        = cpu_req_valid && (state_q.st == ST_IDLE);
    assign map_wr_accept = accept && dec.local_acc && cpu_req_write;

    always_comb begin
        state_d           = state_q;
        state_d.rsp_valid = 1'b0;
        state_d.rsp_err   = 1'b0;
        state_d.dn_valid  = 1'b0;
        case (state_q.st)
            ST_IDLE: begin
                if (accept) begin
                    if (dec.err) begin
                        state_d.rsp_valid = 1'b1;
                        state_d.rsp_err   = 1'b1;
                        state_d.rsp_rdata = '1;
                    end else if (dec.local_acc) begin
                        state_d.rsp_valid = 1'b1;
                        state_d.rsp_rdata = cpu_req_write ? '0
                                          : {{(DATA_W-1){1'b0}}, state_q.map};
                        if (cpu_req_write) state_d.map = cpu_req_wdata[0];
                    end else begin
                        state_d.st       = ST_WAIT;
                        state_d.dn_valid = 1'b1;
                        state_d.dn_kind  = dec.kind;
                        state_d.dn_addr  = dec.addr;
                        state_d.dn_be    = dec.be;
                        state_d.dn_write = cpu_req_write;
                        state_d.dn_wdata = cpu_req_wdata;
                    end
                end
            end
            ST_WAIT: begin
                if (dn_rsp_valid) begin
                    state_d.st        = ST_IDLE;
                    state_d.rsp_valid = 1'b1;
                    state_d.rsp_rdata = dn_rsp_rdata;
                end
            end
            default: state_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cpu_req_ready = (state_q.st == ST_IDLE);
    assign cpu_rsp_valid = state_q.rsp_valid;
    assign cpu_rsp_err   = state_q.rsp_err;
    assign cpu_rsp_rdata = state_q.rsp_rdata;
    assign dn_req_valid  = state_q.dn_valid;
    assign dn_req_kind   = state_q.dn_kind;
    assign dn_req_addr   = state_q.dn_addr;
    assign dn_req_be     = state_q.dn_be;
    assign dn_req_write  = state_q.dn_write;
    assign dn_req_wdata  = state_q.dn_wdata;

    AST_DN_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid |=> !dn_req_valid) else $error("dn pulse"); // R10
    AST_DN_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid |-> $past(cpu_req_valid && cpu_req_ready)) else $error("dn origin"); // R10
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid |-> !cpu_req_ready) else $error("ready while busy"); // R10
    AST_ERR_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_err |-> (cpu_rsp_valid && (cpu_rsp_rdata == 32'hFFFF_FFFF))) else $error("err data"); // R9
    AST_BE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req_valid |-> ($countones(dn_req_be) inside {1, 2, 4})) else $error("be count"); // R8
    AST_INTACK_BYTE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && dn_req_kind == KIND_INTACK) |-> (dn_req_be == 8'h01 && !dn_req_write))
        else $error("intack shape"); // R6
    AST_MAP_CHANGE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state_q.map) |-> $past(map_wr_accept)) else $error("map change"); // R4
endmodule

// File: tb/pci_window_decoder_tb.sv
module pci_window_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_ready;
    logic        cpu_req_write = 1'b0;
    logic [31:0] cpu_req_addr = '0;
    logic [2:0]  cpu_req_size = 3'd1;
    logic [31:0] cpu_req_wdata = '0;
    logic        cpu_rsp_valid, cpu_rsp_err;
    logic [31:0] cpu_rsp_rdata;
    logic        dn_req_valid;
    logic [1:0]  dn_req_kind;
    logic [31:0] dn_req_addr;
    logic [7:0]  dn_req_be;
    logic        dn_req_write;
    logic [31:0] dn_req_wdata;
    logic        dn_rsp_valid = 1'b0;
    logic [31:0] dn_rsp_rdata = '0;

    int checks = 0;
    int fails  = 0;
    bit model_map = 1'b0;

    always #4 clk = ~clk;

    pci_window_decoder u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
        .cpu_req_size(cpu_req_size), .cpu_req_wdata(cpu_req_wdata),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_err(cpu_rsp_err),
        .cpu_rsp_rdata(cpu_rsp_rdata),
        .dn_req_valid(dn_req_valid), .dn_req_kind(dn_req_kind),
        .dn_req_addr(dn_req_addr), .dn_req_be(dn_req_be),
        .dn_req_write(dn_req_write), .dn_req_wdata(dn_req_wdata),
        .dn_rsp_valid(dn_rsp_valid), .dn_rsp_rdata(dn_rsp_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic void model(input logic [31:0] a, input logic [2:0] sz, input bit w,
                                  input bit mp, output bit err, output bit loc,
                                  output logic [1:0] kind, output logic [31:0] da,
                                  output logic [7:0] be, output string req);
        bit szok;
        logic [15:0] port;
        int p;
        szok = (sz == 1) || (sz == 2) || (sz == 4);
        err = 0; loc = 0; kind = 2'b00; da = '0;
        be = 8'(((32'd1 << sz) - 1) << a[1:0]);
        if (a[31:23] == 9'h100) begin
            kind = 2'b01;
            port = mp ? {a[22:12], a[4:0]} : a[15:0];
            da = {16'h0, port};
            loc = (sz == 1) && (port == 16'h0850);
            req = loc ? "R4" : (mp ? "R3" : "R2");
        end else if (a[31:22] == 10'h202) begin
            kind = 2'b10;
            p = 32;
            for (int i = 21; i >= 11; i--) if (a[i]) p = i;
            da = (32'(p) << 11) | {21'h0, a[10:0]};
            req = "R5";
        end else if (a == 32'hBFFF_FFF0) begin
            kind = 2'b11;
            err = w || (sz != 1);
            req = "R6";
        end else if (a >= 32'hC000_0000) begin
            kind = 2'b00;
            da = a - 32'hC000_0000;
            req = "R7";
        end else begin
            err = 1;
            req = "R9";
        end
        if (!szok) begin err = 1; req = "R9"; end
        if (err) loc = 0;
    endfunction

    task automatic access(input logic [31:0] a, input logic [2:0] sz, input bit w,
                          input logic [31:0] wd);
        bit err, loc;
        logic [1:0] kind;
        logic [31:0] da, rd;
        logic [7:0] be;
        string req;
        int dly;
        model(a, sz, w, model_map, err, loc, kind, da, be, req);
        @(negedge clk);
        while (!cpu_req_ready) @(negedge clk);
        cpu_req_valid = 1; cpu_req_addr = a; cpu_req_size = sz;
        cpu_req_write = w; cpu_req_wdata = wd;
        @(negedge clk);
        cpu_req_valid = 0;
        if (err || loc) begin
            chk(dn_req_valid == 0, req, "no downstream request", 32'(dn_req_valid), 0);
            chk(cpu_rsp_valid == 1, req, "local rsp valid", 32'(cpu_rsp_valid), 1);
            chk(cpu_rsp_err == err, req, "rsp err", 32'(cpu_rsp_err), 32'(err));
            if (err) chk(cpu_rsp_rdata == 32'hFFFF_FFFF, "R9", "err rdata", cpu_rsp_rdata, 32'hFFFF_FFFF);
            else begin
                chk(cpu_rsp_rdata == (w ? 32'h0 : 32'(model_map)), "R4", "map rdata",
                    cpu_rsp_rdata, w ? 32'h0 : 32'(model_map));
                if (w) model_map = wd[0];
            end
        end else begin
            chk(dn_req_valid == 1, "R10", "dn_req_valid", 32'(dn_req_valid), 1);
            chk(cpu_req_ready == 0, "R10", "ready while busy", 32'(cpu_req_ready), 0);
            chk(dn_req_kind == kind, req, "kind", 32'(dn_req_kind), 32'(kind));
            chk(dn_req_addr == da, req, "addr", dn_req_addr, da);
            chk(dn_req_be == be, "R8", "be", 32'(dn_req_be), 32'(be));
            chk(dn_req_write == w && dn_req_wdata == wd, "R8", "write/wdata", dn_req_wdata, wd);
            dly = $urandom_range(0, 3);
            for (int c = 0; c < dly; c++) begin
                @(negedge clk);
                chk(dn_req_valid == 0 && cpu_rsp_valid == 0 && cpu_req_ready == 0,
                    "R10", "idle while waiting", {dn_req_valid, cpu_rsp_valid, cpu_req_ready}, 0);
            end
            rd = $urandom;
            dn_rsp_valid = 1; dn_rsp_rdata = rd;
            @(negedge clk);
            dn_rsp_valid = 0;
            chk(cpu_rsp_valid == 1 && cpu_rsp_err == 0, "R10", "rsp valid/err",
                {cpu_rsp_valid, cpu_rsp_err}, 2);
            chk(cpu_rsp_rdata == rd, "R10", "rsp rdata", cpu_rsp_rdata, rd);
        end
    endtask

    function automatic logic [31:0] rand_addr(input int cls);
        case (cls)
            0: return 32'h8000_0000 | ($urandom & 32'h007F_FFFF);
            1: return 32'h8000_0000 | ($urandom & 32'h0000_FFFF);
            2: return 32'h8080_0000 | ($urandom & 32'h003F_FFFF);
            3: return 32'hBFFF_FFF0;
            4: return 32'hC000_0000 | ($urandom & 32'h3FFF_FFFF);
            5: return $urandom & 32'h7FFF_FFFF;
            default: return 32'h80C0_0000 + ($urandom % 32'h3F3F_FFF0);
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(cpu_req_ready == 1, "R1", "reset ready", 32'(cpu_req_ready), 1);
        chk(cpu_rsp_valid == 0 && dn_req_valid == 0, "R1", "reset strobes",
            {cpu_rsp_valid, dn_req_valid}, 0);
        // R1: mode reads back as contiguous
        access(32'h8000_0850, 3'd1, 0, 0);
        // R2 directed, unaligned 4-byte
        access(32'h8012_3CFB, 3'd4, 1, 32'hA5A5_1234);
        // R5 directed: select bit 13 and no select bit
        access(32'h8080_2123, 3'd4, 0, 0);
        access(32'h8080_0004, 3'd2, 0, 0);
        // R6 directed
        access(32'hBFFF_FFF0, 3'd1, 0, 0);
        access(32'hBFFF_FFF0, 3'd1, 1, 32'h11);
        access(32'hBFFF_FFF0, 3'd2, 0, 0);
        // R7 / R9 directed
        access(32'hC000_1002, 3'd2, 0, 0);
        access(32'h7FFF_FFFC, 3'd4, 0, 0);
        access(32'hC000_0000, 3'd3, 0, 0);
        // R4: switch to packed mode, read back, R3 directed
        access(32'h8000_0850, 3'd1, 1, 32'h1);
        access(32'h8004_2010, 3'd1, 0, 0);
        access(32'h807F_F01F, 3'd1, 0, 0);
        access(32'h8000_0850, 3'd1, 0, 0);
        // R4: back to contiguous via packed port address
        access(32'h8004_2010, 3'd1, 1, 32'h0);
        for (int n = 0; n < 400; n++) begin
            int cls;
            logic [2:0] sz;
            cls = $urandom_range(0, 7);
            sz = ($urandom_range(0, 4) == 0) ? 3'($urandom_range(0, 7))
                                             : 3'(1 << $urandom_range(0, 2));
            if (cls == 7)
                access(model_map ? 32'h8004_2010 : 32'h8000_0850, 3'd1,
                       1'($urandom_range(0, 1)), $urandom);
            else
                access(rand_addr(cls), sz, 1'($urandom_range(0, 1)), $urandom);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule